// File: doc/BRIEF.md
# Prescaled Countdown Interval Timer

This block is a programmable interval timer that counts down from a software-loaded start value. Software reaches it through a small synchronous register port. One register holds the start value, one returns the live count, and one holds a run bit and a repeat bit. Writing the control register with the run bit set copies the start value into the counter. From then on the counter steps down by one on every active tick. When it steps from one to zero, the block raises a single-cycle expiry pulse, and raises an interrupt request with it if that option is built in.

The tick source is chosen when the block is built. It can be every clock, one of four fixed-interval strobes, the expiry pulse of one of four peer timers, or an external tick pin. Because the expiry output has the same one-cycle form as these tick inputs, timers can be chained. The first timer divides the clock, and the next one counts the first one's expiries. After expiry the timer either reloads the start value and keeps going, or stops with its count at zero.

Top module: `prescaled_countdown_timer`

## Requirements
- R1: After reset, the start value, the count and the control register all read zero, and `expiry` and `irq` are low.
- R2: A write to the control register (address 2) with bit 0 set loads the counter from the start value. With ticks on every clock and a start value P, the first expiry pulse is high in the P-th cycle after the write's capturing edge. A count read sampled k ticks after the load returns P-k.
- R3: Each expiry is one clock cycle of `expiry` high. `irq` follows `expiry` when IRQ_ON=1 and stays low when IRQ_ON=0.
- R4: With control bit 1 clear (one-shot), expiry clears control bit 0, leaves the count at zero, and no further pulse follows.
- R5: With control bit 1 set (repeat), expiry reloads the counter from the start value, so pulses recur every P ticks.
- R6: Writing the start value (address 0) while counting leaves the current count untouched. The new value is used from the next reload.
- R7: Enabling with a start value of zero produces no expiry pulse, and the run bit stays set.
- R8: The start value keeps only its low CNT_W bits. The longest interval is 2^CNT_W-1 ticks.
- R9: TICK_SRC selects the tick: 0 = every clock, 1-4 = `strobe_in[0..3]`, 5-8 = `peer_expiry[0..3]`, 9 = `ext_tick`. The counter moves only on the selected tick, and every other tick input has no effect.
- R10: The count register (address 1) reads zero when READABLE=0.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_rd` is high and is zero otherwise. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 start value, 1 count, 2 control |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| strobe_in | input | 4 | Fixed-interval strobes (sources 1-4) |
| peer_expiry | input | 4 | Peer timer expiry pulses (sources 5-8) |
| ext_tick | input | 1 | External tick (source 9) |
| expiry | output | 1 | One-cycle pulse on reaching zero |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two 8-bit instances. The first ticks on every clock, is readable and raises interrupts. Its 8-bit width brings the 255-tick maximum interval and the truncation of a wide start-value write within a short run. The second selects peer source 6, is not readable and has no interrupt. It is fed by the first instance's expiry while random noise drives all its other tick inputs, which exercises cascaded counting, the ignored inputs, the gated count read-back and the tied-off interrupt.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   localparam int unsigned BUS_DW = 32;
   localparam int unsigned BUS_AW = 2;

   typedef enum logic [BUS_AW-1:0] {
      REG_START = 2'd0,
      REG_COUNT = 2'd1,
      REG_CTRL  = 2'd2,
      REG_SPARE = 2'd3
   } reg_sel_e;

   localparam int unsigned CTRL_RUN_BIT    = 0;
   localparam int unsigned CTRL_REPEAT_BIT = 1;

   localparam int unsigned SRC_FREE      = 0;
   localparam int unsigned SRC_STROBE_LO = 1;
   localparam int unsigned SRC_STROBE_HI = 4;
   localparam int unsigned SRC_PEER_LO   = 5;
   localparam int unsigned SRC_PEER_HI   = 8;
   localparam int unsigned SRC_PIN       = 9;
   localparam int unsigned SRC_LANES     = 4;
endpackage

// File: rtl/cdt_tick_select.sv
module cdt_tick_select
   import cdt_pkg::*;
#(
   parameter int unsigned TICK_SRC = 0
) (
   input  logic [SRC_LANES-1:0] strobe_i,
   input  logic [SRC_LANES-1:0] peer_i,
   input  logic                 pin_i,
   output logic                 tick_o
);
   generate
      if (TICK_SRC == SRC_FREE) begin : g_free
         assign tick_o = 1'b1;
      end else if (TICK_SRC >= SRC_STROBE_LO && TICK_SRC <= SRC_STROBE_HI) begin : g_strobe
         localparam int unsigned LANE = TICK_SRC - SRC_STROBE_LO;
         assign tick_o = strobe_i[LANE];
      end else if (TICK_SRC >= SRC_PEER_LO && TICK_SRC <= SRC_PEER_HI) begin : g_peer
         localparam int unsigned LANE = TICK_SRC - SRC_PEER_LO;
         assign tick_o = peer_i[LANE];
      end else if (TICK_SRC == SRC_PIN) begin : g_pin
         assign tick_o = pin_i;
      end else begin : g_bad
         $error("cdt_tick_select: TICK_SRC out of range");
         assign tick_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cdt_core.sv
module cdt_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ctrl_wr_i,
   input  logic             run_wdata_i,
   input  logic             repeat_i,
   input  logic [CNT_W-1:0] start_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             run_o,
   output logic             expiry_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic step_ok;
   assign step_ok = run_o && tick_i && (count_o != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_o  <= '0;
         run_o    <= 1'b0;
         expiry_o <= 1'b0;
      end else begin
         expiry_o <= 1'b0;
         if (ctrl_wr_i) begin
            run_o <= run_wdata_i;
            if (run_wdata_i) count_o <= start_val_i;
         end else if (step_ok) begin
            if (count_o == ONE) begin
               expiry_o <= 1'b1;
               if (repeat_i) begin
                  count_o <= start_val_i;
               end else begin
                  count_o <= '0;
                  run_o   <= 1'b0;
               end
            end else begin
               count_o <= count_o - ONE;
            end
         end
      end
   end

   assert_load_on_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_i && run_wdata_i) |=> (count_o == $past(start_val_i)));
   assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expiry_o && !repeat_i) |-> (count_o == '0 && !run_o));
   assert_repeat_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (expiry_o && repeat_i) |-> (count_o == $past(start_val_i)));
   assert_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == '0) |=> !expiry_o);
   assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !ctrl_wr_i) |=> $stable(count_o));
   assert_expiry_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      expiry_o |-> $past(tick_i));
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
   import cdt_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter bit          READABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_AW-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [BUS_DW-1:0] wdata_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              run_i,
   output logic [CNT_W-1:0]  start_val_o,
   output logic              repeat_o,
   output logic              ctrl_wr_o,
   output logic              run_wdata_o,
   output logic [BUS_DW-1:0] rdata_o
);
   logic [BUS_DW-1:0] count_view;
   logic [BUS_DW-1:0] start_view;
   logic [BUS_DW-1:0] ctrl_view;
   logic [BUS_DW-1:0] rd_mux;

   assign ctrl_wr_o   = wr_i && (addr_i == REG_CTRL);
   assign run_wdata_o = wdata_i[CTRL_RUN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_val_o <= '0;
         repeat_o    <= 1'b0;
      end else if (wr_i) begin
         if (addr_i == REG_START) start_val_o <= wdata_i[CNT_W-1:0];
         if (addr_i == REG_CTRL)  repeat_o    <= wdata_i[CTRL_REPEAT_BIT];
      end
   end

   generate
      if (READABLE) begin : g_count_rd
         always_comb begin
            count_view = '0;
            count_view[CNT_W-1:0] = count_i;
         end
      end else begin : g_count_hidden
         assign count_view = '0;
      end
   endgenerate

   always_comb begin
      start_view = '0;
      start_view[CNT_W-1:0] = start_val_o;
      ctrl_view = '0;
      ctrl_view[CTRL_RUN_BIT]    = run_i;
      ctrl_view[CTRL_REPEAT_BIT] = repeat_o;
      case (addr_i)
         REG_START: rd_mux = start_view;
         REG_COUNT: rd_mux = count_view;
         REG_CTRL:  rd_mux = ctrl_view;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= rd_mux;
      else           rdata_o <= '0;
   end

   assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> (rdata_o == '0));
   assert_spare_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && addr_i == REG_SPARE) |=> (rdata_o == '0));
endmodule

// File: rtl/prescaled_countdown_timer.sv
module prescaled_countdown_timer
   import cdt_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned TICK_SRC = 0,
   parameter bit          READABLE = 1'b1,
   parameter bit          IRQ_ON   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  reg_addr,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic [3:0]  strobe_in,
   input  logic [3:0]  peer_expiry,
   input  logic        ext_tick,
   output logic        expiry,
   output logic        irq
);
   generate
      if (CNT_W < 1 || CNT_W > BUS_DW) begin : g_bad_width
         $error("prescaled_countdown_timer: CNT_W must be 1..32");
      end
      if (TICK_SRC > SRC_PIN) begin : g_bad_src
         $error("prescaled_countdown_timer: TICK_SRC must be 0..9");
      end
   endgenerate

   logic             tick;
   logic             ctrl_wr;
   logic             run_wdata;
   logic             repeat_mode;
   logic             run;
   logic [CNT_W-1:0] start_val;
   logic [CNT_W-1:0] count;

   cdt_tick_select #(.TICK_SRC(TICK_SRC)) u_tick (
      .strobe_i (strobe_in),
      .peer_i   (peer_expiry),
      .pin_i    (ext_tick),
      .tick_o   (tick)
   );

   cdt_regs #(.CNT_W(CNT_W), .READABLE(READABLE)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (reg_addr),
      .wr_i        (reg_wr),
      .rd_i        (reg_rd),
      .wdata_i     (reg_wdata),
      .count_i     (count),
      .run_i       (run),
      .start_val_o (start_val),
      .repeat_o    (repeat_mode),
      .ctrl_wr_o   (ctrl_wr),
      .run_wdata_o (run_wdata),
      .rdata_o     (reg_rdata)
   );

   cdt_core #(.CNT_W(CNT_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .ctrl_wr_i   (ctrl_wr),
      .run_wdata_i (run_wdata),
      .repeat_i    (repeat_mode),
      .start_val_i (start_val),
      .count_o     (count),
      .run_o       (run),
      .expiry_o    (expiry)
   );

   generate
      if (IRQ_ON) begin : g_irq
         assign irq = expiry;
      end else begin : g_no_irq
         assign irq = 1'b0;
      end
   endgenerate

   assert_pulse_after_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expiry) |-> $past(run));
endmodule

// File: tb/prescaled_countdown_timer_test.sv
module prescaled_countdown_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr0 = 1'b0, rd0 = 1'b0, wr1 = 1'b0, rd1 = 1'b0;
   logic [31:0] rdata0, rdata1;
   logic [3:0]  noise = '0;
   logic        noise_pin = 1'b0;
   logic        exp0, irq0, exp1, irq1;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;
   int q0[$];
   int q1[$];

   always #5 clk = ~clk;

   prescaled_countdown_timer #(.CNT_W(8), .TICK_SRC(0), .READABLE(1'b1), .IRQ_ON(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr0), .reg_rd(rd0),
      .reg_wdata(wdata), .reg_rdata(rdata0), .strobe_in(noise), .peer_expiry(noise),
      .ext_tick(noise_pin), .expiry(exp0), .irq(irq0)
   );

   prescaled_countdown_timer #(.CNT_W(8), .TICK_SRC(6), .READABLE(1'b0), .IRQ_ON(1'b0)) uut_peer (
      .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr1), .reg_rd(rd1),
      .reg_wdata(wdata), .reg_rdata(rdata1), .strobe_in(noise),
      .peer_expiry({noise[3], noise[2], exp0, noise[0]}),
      .ext_tick(noise_pin), .expiry(exp1), .irq(irq1)
   );

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         noise = lfsr[3:0];
         noise_pin = lfsr[7];
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: pops expected expiry cycles and compares
   always @(negedge clk) begin
      if (mon_on) begin
         if (exp0) begin
            check(irq0 == 1'b1, "R3 irq follows expiry", irq0, 1);
            if (q0.size() == 0) check(1'b0, "R3 unexpected pulse on uut", cyc, -1);
            else begin
               int e;
               e = q0.pop_front();
               check(cyc == e, "R2/R5 uut expiry cycle", cyc, e);
            end
         end else if (irq0) begin
            check(1'b0, "R3 irq without expiry", irq0, 0);
         end
         if (exp1) begin
            check(irq1 == 1'b0, "R3 irq tied low", irq1, 0);
            if (q1.size() == 0) check(1'b0, "R9 unexpected pulse on peer", cyc, -1);
            else begin
               int e;
               e = q1.pop_front();
               check(cyc == e, "R9 peer expiry cycle", cyc, e);
            end
         end
      end
   end

   task automatic wr_reg(input int which, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d;
      if (which == 0) wr0 = 1'b1; else wr1 = 1'b1;
      @(negedge clk);
      wr0 = 1'b0; wr1 = 1'b0;
   endtask

   task automatic rd_reg(input int which, input logic [1:0] a, output logic [31:0] d, output int c0);
      @(negedge clk);
      addr = a; c0 = cyc;
      if (which == 0) rd0 = 1'b1; else rd1 = 1'b1;
      @(negedge clk);
      rd0 = 1'b0; rd1 = 1'b0;
      d = (which == 0) ? rdata0 : rdata1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic drain(input int which, input int limit);
      for (int i = 0; i < limit; i++) begin
         if ((which == 0 ? q0.size() : q1.size()) == 0) break;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int c0, e;
      idle(3);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R1 reset state
      check(exp0 == 1'b0 && irq0 == 1'b0, "R1 outputs low", {exp0, irq0}, 0);
      rd_reg(0, 2'd0, d, c0); check(d == 0, "R1 start value", d, 0);
      rd_reg(0, 2'd1, d, c0); check(d == 0, "R1 count", d, 0);
      rd_reg(0, 2'd2, d, c0); check(d == 0, "R1 control", d, 0);
      rd_reg(0, 2'd3, d, c0); check(d == 0, "R11 spare address", d, 0);
      check(rdata0 == 0, "R11 rdata idle", rdata0, 0);

      // R7 zero start value stays idle
      wr_reg(0, 2'd0, 32'd0);
      wr_reg(0, 2'd2, 32'd1);
      idle(20);
      rd_reg(0, 2'd2, d, c0); check(d == 1, "R7 run bit kept", d, 1);
      wr_reg(0, 2'd2, 32'd0);

      // R2 / R4 one-shot of 5
      wr_reg(0, 2'd0, 32'd5);
      wr_reg(0, 2'd2, 32'd1);
      e = cyc; q0.push_back(e + 5);
      drain(0, 40);
      rd_reg(0, 2'd2, d, c0); check(d == 0, "R4 run bit cleared", d, 0);
      rd_reg(0, 2'd1, d, c0); check(d == 0, "R4 count holds zero", d, 0);
      idle(12);

      // R2 readback, R6 start value change mid-run, R5 repeat
      wr_reg(0, 2'd0, 32'd20);
      wr_reg(0, 2'd2, 32'd3);
      e = cyc;
      q0.push_back(e + 20); q0.push_back(e + 27); q0.push_back(e + 34);
      idle(4);
      rd_reg(0, 2'd1, d, c0); check(d == 20 - (c0 - e), "R2 count readback", d, 20 - (c0 - e));
      wr_reg(0, 2'd0, 32'd7);
      rd_reg(0, 2'd1, d, c0); check(d == 20 - (c0 - e), "R6 count undisturbed", d, 20 - (c0 - e));
      drain(0, 80);
      wr_reg(0, 2'd2, 32'd0);
      idle(15);

      // R5 repeat of 4
      wr_reg(0, 2'd0, 32'd4);
      wr_reg(0, 2'd2, 32'd3);
      e = cyc;
      for (int k = 1; k <= 3; k++) q0.push_back(e + 4 * k);
      drain(0, 40);
      wr_reg(0, 2'd2, 32'd0);
      idle(12);

      // R8 truncation and maximum interval
      wr_reg(0, 2'd0, 32'h0000_01FF);
      rd_reg(0, 2'd0, d, c0); check(d == 255, "R8 start value truncated", d, 255);
      wr_reg(0, 2'd2, 32'd1);
      e = cyc; q0.push_back(e + 255);
      drain(0, 400);
      check(q0.size() == 0, "R8 max interval reached", q0.size(), 0);

      // R9 / R10 cascade on peer source 6
      wr_reg(1, 2'd0, 32'd3);
      wr_reg(1, 2'd2, 32'd3);
      rd_reg(1, 2'd1, d, c0); check(d == 0, "R10 count hidden", d, 0);
      rd_reg(1, 2'd0, d, c0); check(d == 3, "R9 peer start value", d, 3);
      idle(30);  // only noise on unselected inputs: no pulse allowed
      wr_reg(0, 2'd0, 32'd4);
      wr_reg(0, 2'd2, 32'd3);
      e = cyc;
      for (int k = 1; k <= 6; k++) q0.push_back(e + 4 * k);
      q1.push_back(e + 13); q1.push_back(e + 25);
      drain(1, 60);
      wr_reg(0, 2'd2, 32'd0);
      check(q0.size() == 0, "R9 source pulses consumed", q0.size(), 0);
      idle(20);
      wr_reg(1, 2'd2, 32'd0);
      idle(5);
      check(q0.size() == 0 && q1.size() == 0, "R3 all expected pulses seen",
            q0.size() + q1.size(), 0);
      finish_run();
   end
endmodule